// File: doc/BRIEF.md
# AC-link Frame Controller

This block is the controller end of a five-wire audio codec serial link. The codec drives the bit clock, and the whole block runs from it. While `enable` is high, the block counts 256 bit clocks per frame. It raises a frame sync at the start of each frame and shifts out a 256-bit frame on `sdata_out`. The frame is a 16-bit tag followed by twelve 20-bit slots. At the same time, the block collects the codec's frame from `sdata_in` and presents it in parallel.

On the parallel side, the system supplies a tag word and twelve slot words. The block copies them into a shadow register at the edge that starts each frame, so the parallel inputs can change at any time during a frame. The outgoing valid-frame flag is generated by the block from the per-slot valid flags, so it always agrees with them. Each completed received frame is reported with a one-cycle `rx_done` pulse. The received tag and slots then stay stable until the next pulse.

Top module: `ac_link_ctrl`

## Requirements
- R1: The first rising edge of `bit_clk` with `enable` high drives `sync` high. `sync` stays high for 16 bit-clock cycles and rises again every 256 cycles while `enable` stays high.
- R2: Outgoing frame bit 0 is driven on the rising edge after the edge that raises `sync`, and one further bit follows on each rising edge. Bit 255 is driven on the edge that raises the next `sync`. The order is the 16-bit tag, then slot 0 (`tx_slots[19:0]`) through slot 11 (`tx_slots[239:220]`), each element most significant bit first.
- R3: Frame bit 0 (the valid-frame flag) is the OR of `tx_tag[14:3]`. Frame bits 1 to 12 are `tx_tag[14:3]` (the per-slot valid flags for slot 0 to slot 11). Frame bits 13 to 15 are zero. `tx_tag[15]` and `tx_tag[2:0]` have no effect on `sdata_out`.
- R4: Tag and slot inputs are captured at the rising edge that raises `sync`. A change to them later in the frame alters only the following frame.
- R5: `sdata_in` is sampled on falling edges of `bit_clk`. The sample taken after the (k+1)-th rising edge of a frame (edge 0 raises `sync`) is frame bit k. `rx_tag` holds frame bits 0 to 15, most significant bit first: `rx_tag[15]` is codec ready and `rx_tag[14:3]` are the slot valid flags. Slot j is `rx_slots[j*20 +: 20]`, most significant bit first.
- R6: `rx_done` is high for exactly one cycle per received frame. It rises on the rising edge after the edge that raises the next `sync`, and the received outputs update on that same edge.
- R7: On the first rising edge with `enable` low, `sync` and `sdata_out` go low and stay low. No `rx_done` pulse is produced while disabled, and a partly received frame is discarded.
- R8: While `rst_n` is low, every output is zero. Reset is applied at once and released on the second rising edge after `rst_n` goes high.
- R9: After `enable` rises, no `rx_done` pulse occurs during the first frame. The first pulse reports that first complete frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock supplied by the codec |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs framing while high |
| tx_tag | input | 16 | Outgoing tag; bits 14:3 are slot valid flags |
| tx_slots | input | 240 | Outgoing slots, slot j at bits j*20 +: 20 |
| sdata_in | input | 1 | Serial data from the codec |
| sync | output | 1 | Frame sync, active high |
| sdata_out | output | 1 | Serial data to the codec |
| rx_tag | output | 16 | Last received tag |
| rx_slots | output | 240 | Last received slots, slot j at bits j*20 +: 20 |
| rx_done | output | 1 | One-cycle pulse when a received frame is complete |

## Verification
`sync` and `sdata_out` are registered on rising edges. The first tag bit therefore appears one rising edge after `sync` rises, and bit k appears k+1 edges after it. The bench reads them at each falling edge that follows. The codec model drives bit k just after rising edge k+1, so the block's falling-edge sample lands in the middle of the bit. A full frame's `rx_done` and received words are then due one rising edge after the next `sync` rise, and the bench checks them at the falling edge after that. Disable, re-enable and reset are each checked at the first falling edge after the rising edge that must act on them.

// File: rtl/ac_link_pkg.sv
package ac_link_pkg;

  localparam int unsigned DEF_TAG_W  = 16;
  localparam int unsigned DEF_SLOT_W = 20;
  localparam int unsigned DEF_NSLOT  = 12;
  localparam int unsigned DEF_SYNC_W = 16;

  // Total serial bits per frame: tag element plus all slot elements.
  function automatic int unsigned frame_bits(input int unsigned tag_w,
                                             input int unsigned slot_w,
                                             input int unsigned nslot);
    return tag_w + slot_w * nslot;
  endfunction

endpackage

// File: rtl/ac_link_timer.sv
module ac_link_timer #(
  parameter int unsigned FRAME_W = 256,
  parameter int unsigned SYNC_W  = 16,
  parameter int unsigned POS_W   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic sync_o,
  output logic load_o,
  output logic fin_o,
  output logic arm_o
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_W - 1);

  logic [POS_W-1:0] pos_q, pos_n;
  logic             sync_q, sync_n;

  always_comb begin
    if (enable) begin
      pos_n = (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
    end else begin
      pos_n = LAST_POS;
    end
    sync_n = enable && (pos_n < POS_W'(SYNC_W));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= LAST_POS;
      sync_q <= 1'b0;
    end else begin
      pos_q  <= pos_n;
      sync_q <= sync_n;
    end
  end

  assign sync_o = sync_q;
  assign load_o = enable && (pos_n == '0);
  assign fin_o  = enable && (pos_n == POS_W'(1));
  assign arm_o  = enable && (pos_n == POS_W'(2));

  // R1: sync only rises as the position counter starts a frame
  assert_sync_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_q) |-> (pos_q == '0));

  // R1: while running, sync falls exactly after SYNC_W cycles
  assert_sync_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sync_q) && $past(enable)) |-> (pos_q == POS_W'(SYNC_W)));

  // R7: a low enable parks the counter and drops sync on the next edge
  assert_park_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!sync_q && (pos_q == LAST_POS)));

endmodule

// File: rtl/ac_link_tx.sv
module ac_link_tx #(
  parameter int unsigned TAG_W   = 16,
  parameter int unsigned SLOT_W  = 20,
  parameter int unsigned NSLOT   = 12,
  parameter int unsigned FRAME_W = 256
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic                    load,
  input  logic [TAG_W-1:0]        tag_i,
  input  logic [NSLOT*SLOT_W-1:0] slots_i,
  output logic                    sdata_o
);

  localparam int unsigned PAD_W = TAG_W - 1 - NSLOT;

  logic [FRAME_W-1:0] frame_w;
  logic [FRAME_W-1:0] sh_q, sh_n;
  logic               sd_q, sd_n;
  logic               unused_tag_bits;

  // Tag: computed valid-frame flag, slot valid flags, zero padding.
  assign frame_w[FRAME_W-1]            = |tag_i[TAG_W-2 -: NSLOT];
  assign frame_w[FRAME_W-2 -: NSLOT]   = tag_i[TAG_W-2 -: NSLOT];
  assign frame_w[FRAME_W-TAG_W +: PAD_W] = '0;
  assign unused_tag_bits = ^{tag_i[TAG_W-1], tag_i[PAD_W-1:0]};

  generate
    for (genvar j = 0; j < NSLOT; j++) begin : g_slot
      assign frame_w[FRAME_W-TAG_W-1-j*SLOT_W -: SLOT_W] = slots_i[j*SLOT_W +: SLOT_W];
    end
  endgenerate

  always_comb begin
    if (!enable) begin
      sh_n = '0;
      sd_n = 1'b0;
    end else if (load) begin
      sh_n = frame_w;
      sd_n = sh_q[FRAME_W-1];
    end else begin
      sh_n = {sh_q[FRAME_W-2:0], 1'b0};
      sd_n = sh_q[FRAME_W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      sd_q <= 1'b0;
    end else begin
      sh_q <= sh_n;
      sd_q <= sd_n;
    end
  end

  assign sdata_o = sd_q;

  // R7: outgoing line goes quiet one edge after disable
  assert_quiet_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !sd_q);

endmodule

// File: rtl/ac_link_rx.sv
module ac_link_rx #(
  parameter int unsigned TAG_W   = 16,
  parameter int unsigned SLOT_W  = 20,
  parameter int unsigned NSLOT   = 12,
  parameter int unsigned FRAME_W = 256
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic                    arm,
  input  logic                    fin,
  input  logic                    sdata_i,
  output logic [TAG_W-1:0]        tag_o,
  output logic [NSLOT*SLOT_W-1:0] slots_o,
  output logic                    done_o
);

  logic               samp_q;
  logic [FRAME_W-2:0] sh_q, sh_n;
  logic [FRAME_W-1:0] frame_q, frame_n;
  logic               armed_q, armed_n;
  logic               done_q, done_n;

  // Falling-edge capture of the codec's rising-edge data.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
    end else begin
      samp_q <= sdata_i;
    end
  end

  always_comb begin
    sh_n    = enable ? {sh_q[FRAME_W-3:0], samp_q} : '0;
    if (!enable) begin
      armed_n = 1'b0;
    end else if (arm) begin
      armed_n = 1'b1;
    end else begin
      armed_n = armed_q;
    end
    done_n  = enable && fin && armed_q;
    frame_n = done_n ? {sh_q, samp_q} : frame_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      frame_q <= '0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      sh_q    <= sh_n;
      frame_q <= frame_n;
      armed_q <= armed_n;
      done_q  <= done_n;
    end
  end

  assign tag_o  = frame_q[FRAME_W-1 -: TAG_W];
  assign done_o = done_q;

  generate
    for (genvar j = 0; j < NSLOT; j++) begin : g_slot
      assign slots_o[j*SLOT_W +: SLOT_W] = frame_q[FRAME_W-TAG_W-1-j*SLOT_W -: SLOT_W];
    end
  endgenerate

  // R6: the completion strobe never lasts two cycles
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R9: no completion until a frame start has been seen
  assert_unarmed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |=> !done_q);

endmodule

// File: rtl/ac_link_ctrl.sv
module ac_link_ctrl #(
  parameter int unsigned TAG_W  = ac_link_pkg::DEF_TAG_W,
  parameter int unsigned SLOT_W = ac_link_pkg::DEF_SLOT_W,
  parameter int unsigned NSLOT  = ac_link_pkg::DEF_NSLOT,
  parameter int unsigned SYNC_W = ac_link_pkg::DEF_SYNC_W
) (
  input  logic                    bit_clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic [TAG_W-1:0]        tx_tag,
  input  logic [NSLOT*SLOT_W-1:0] tx_slots,
  input  logic                    sdata_in,
  output logic                    sync,
  output logic                    sdata_out,
  output logic [TAG_W-1:0]        rx_tag,
  output logic [NSLOT*SLOT_W-1:0] rx_slots,
  output logic                    rx_done
);

  localparam int unsigned FRAME_W = ac_link_pkg::frame_bits(TAG_W, SLOT_W, NSLOT);
  localparam int unsigned POS_W   = $clog2(FRAME_W);

  logic rst_meta_q, rst_sync_q;
  logic load, fin, arm;

  // Reset asserts at once and is released two edges later.
  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  ac_link_timer #(
    .FRAME_W(FRAME_W),
    .SYNC_W (SYNC_W),
    .POS_W  (POS_W)
  ) u_timer (
    .clk   (bit_clk),
    .rst_n (rst_sync_q),
    .enable(enable),
    .sync_o(sync),
    .load_o(load),
    .fin_o (fin),
    .arm_o (arm)
  );

  ac_link_tx #(
    .TAG_W  (TAG_W),
    .SLOT_W (SLOT_W),
    .NSLOT  (NSLOT),
    .FRAME_W(FRAME_W)
  ) u_tx (
    .clk    (bit_clk),
    .rst_n  (rst_sync_q),
    .enable (enable),
    .load   (load),
    .tag_i  (tx_tag),
    .slots_i(tx_slots),
    .sdata_o(sdata_out)
  );

  ac_link_rx #(
    .TAG_W  (TAG_W),
    .SLOT_W (SLOT_W),
    .NSLOT  (NSLOT),
    .FRAME_W(FRAME_W)
  ) u_rx (
    .clk    (bit_clk),
    .rst_n  (rst_sync_q),
    .enable (enable),
    .arm    (arm),
    .fin    (fin),
    .sdata_i(sdata_in),
    .tag_o  (rx_tag),
    .slots_o(rx_slots),
    .done_o (rx_done)
  );

  // R6: completion lands on the second cycle of a sync pulse
  assert_done_in_sync_R6: assert property (@(posedge bit_clk) disable iff (!rst_sync_q)
    rx_done |-> (sync && $past(sync)));

endmodule

// File: tb/sim_ac_link_ctrl.sv
module sim_ac_link_ctrl;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         enable;
  logic [15:0]  tx_tag;
  logic [239:0] tx_slots;
  logic         sdata_in;
  logic         sync;
  logic         sdata_out;
  logic [15:0]  rx_tag;
  logic [239:0] rx_slots;
  logic         rx_done;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  bit          prev_valid = 1'b0;
  logic [15:0] prev_rtag;
  logic [15:0] prev_rseed;

  always #4 clk = ~clk;

  ac_link_ctrl u0 (
    .bit_clk  (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .tx_tag   (tx_tag),
    .tx_slots (tx_slots),
    .sdata_in (sdata_in),
    .sync     (sync),
    .sdata_out(sdata_out),
    .rx_tag   (rx_tag),
    .rx_slots (rx_slots),
    .rx_done  (rx_done)
  );

  // Vector: {tx tag, tx slot seed, rx tag, rx slot seed}
  localparam int NVEC = 6;
  localparam logic [63:0] VECS [NVEC] = '{
    64'h7FF8_1234_8000_A5A5,
    64'h0000_FFFF_FFFF_0001,
    64'h8007_0F0F_4001_7777,
    64'h0008_3C3C_0000_0000,
    64'h4000_BEEF_FFF8_CAFE,
    64'hFFFF_5A5A_8FF0_0F0F
  };

  function automatic logic [239:0] slots_of(input logic [15:0] seed);
    logic [239:0] s;
    for (int j = 0; j < 12; j++) begin
      s[j*20 +: 20] = {seed[3:0] ^ 4'(j), seed ^ (16'h1357 * 16'(j + 1))};
    end
    return s;
  endfunction

  function automatic logic [255:0] tx_frame(input logic [15:0] tag, input logic [239:0] sl);
    logic [255:0] f;
    f[255]     = |tag[14:3];
    f[254:243] = tag[14:3];
    f[242:240] = 3'b000;
    for (int j = 0; j < 12; j++) f[239 - j*20 -: 20] = sl[j*20 +: 20];
    return f;
  endfunction

  function automatic logic [255:0] rx_frame(input logic [15:0] tag, input logic [239:0] sl);
    logic [255:0] f;
    f[255:240] = tag;
    for (int j = 0; j < 12; j++) f[239 - j*20 -: 20] = sl[j*20 +: 20];
    return f;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Entered just after the falling edge that follows the sync-raising edge.
  task automatic run_frame(input logic [15:0] ttag, input logic [239:0] tsl,
                           input logic [15:0] rtag, input logic [15:0] rseed,
                           input logic [15:0] ntag, input logic [239:0] nsl);
    logic [255:0] got, expf, rxf;
    logic [255:0] sync_got, sync_exp;
    int extra;
    extra = 0;
    expf  = tx_frame(ttag, tsl);
    rxf   = rx_frame(rtag, slots_of(rseed));
    for (int k = 0; k < 256; k++) begin
      @(posedge clk); #1 sdata_in = rxf[255 - k];
      @(negedge clk); #1;
      got[255 - k]      = sdata_out;
      sync_got[255 - k] = sync;
      sync_exp[255 - k] = (k < 15) || (k == 255);
      if (k == 0) begin
        // R6 / R9: completion of the previous frame is due here
        check(rx_done == prev_valid, "R6,R9", "rx_done at frame start",
              256'(rx_done), 256'(prev_valid));
        if (prev_valid) begin
          check(rx_tag == prev_rtag, "R5", "rx_tag", 256'(rx_tag), 256'(prev_rtag));
          check(rx_slots == slots_of(prev_rseed), "R5", "rx_slots",
                256'(rx_slots), 256'(slots_of(prev_rseed)));
        end
      end else if (rx_done) begin
        extra++;
      end
      if (k == 100) begin
        tx_tag   = ntag;   // R4: mid-frame change must not show in this frame
        tx_slots = nsl;
      end
    end
    check(got == expf, "R2,R4", "serial frame", got, expf);
    check(got[255] == |ttag[14:3] && got[242:240] == 3'b000, "R3", "tag flag and padding",
          256'({got[255], got[242:240]}), 256'({|ttag[14:3], 3'b000}));
    check(sync_got == sync_exp, "R1", "sync pattern", sync_got, sync_exp);
    check(extra == 0, "R6", "extra rx_done pulses", 256'(extra), 256'(0));
    prev_valid = 1'b1;
    prev_rtag  = rtag;
    prev_rseed = rseed;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int quiet_bad;
    rst_n    = 1'b0;
    enable   = 1'b0;
    sdata_in = 1'b0;
    tx_tag   = VECS[0][63:48];
    tx_slots = slots_of(VECS[0][47:32]);
    repeat (3) @(negedge clk);
    #1;
    // R8: reset state
    check({sync, sdata_out, rx_done} == 3'b000 && rx_tag == '0 && rx_slots == '0,
          "R8", "outputs in reset", 256'({sync, sdata_out, rx_done}), 256'(0));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check({sync, sdata_out, rx_done} == 3'b000, "R7", "idle while disabled",
          256'({sync, sdata_out, rx_done}), 256'(0));

    enable = 1'b1;
    @(negedge clk); #1;
    check(sync == 1'b1, "R1", "sync on first enabled edge", 256'(sync), 256'(1));

    // Table walk: consecutive frames, next vector applied mid-frame
    for (int i = 0; i < NVEC; i++) begin
      logic [15:0]  ntag;
      logic [239:0] nsl;
      if (i + 1 < NVEC) begin
        ntag = VECS[i+1][63:48];
        nsl  = slots_of(VECS[i+1][47:32]);
      end else begin
        ntag = 16'h7FF8;
        nsl  = '1;
      end
      run_frame(VECS[i][63:48], slots_of(VECS[i][47:32]),
                VECS[i][31:16], VECS[i][15:0], ntag, nsl);
    end
    // Trailing frame reports the last table entry's received data
    run_frame(16'h7FF8, '1, 16'hC000, 16'h2468, 16'h7FF8, '1);

    // R7: disable just after a sync rise, with a 1 pending on the line
    enable = 1'b0;
    @(negedge clk); #1;
    check(sync == 1'b0 && sdata_out == 1'b0 && rx_done == 1'b0, "R7", "outputs after disable",
          256'({sync, sdata_out, rx_done}), 256'(0));
    quiet_bad = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk); #1;
      if (sync || sdata_out || rx_done) quiet_bad++;
    end
    check(quiet_bad == 0, "R7", "quiet while disabled", 256'(quiet_bad), 256'(0));

    // R9: restart, no completion in the first frame, then the full frame
    prev_valid = 1'b0;
    tx_tag     = VECS[0][63:48];
    tx_slots   = slots_of(VECS[0][47:32]);
    enable     = 1'b1;
    @(negedge clk); #1;
    check(sync == 1'b1, "R1", "sync on re-enable", 256'(sync), 256'(1));
    run_frame(VECS[0][63:48], slots_of(VECS[0][47:32]), VECS[2][31:16], VECS[2][15:0],
              VECS[3][63:48], slots_of(VECS[3][47:32]));
    run_frame(VECS[3][63:48], slots_of(VECS[3][47:32]), VECS[4][31:16], VECS[4][15:0],
              VECS[3][63:48], slots_of(VECS[3][47:32]));
    @(posedge clk); #1;
    @(negedge clk); #1;
    check(rx_done == 1'b1 && rx_tag == VECS[4][31:16], "R6", "final completion",
          256'({rx_done, rx_tag}), 256'({1'b1, VECS[4][31:16]}));

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule